// File: doc/BRIEF.md
# Quadratic residue to complex residue converter

This block sits at the output of one residue channel of a complex arithmetic datapath that works in the quadratic residue number system. For a single prime modulus `m`, a complex value is carried as a residue pair `(Z, Zh)`. The pair is related to the real and imaginary residues through a square root `q` of −1 modulo `m`, with `Z = re + q·im` and `Zh = re − q·im`. The block recovers `re` and `im` modulo `m` from such a pair.

It forms the modular sum `Z + Zh` and the modular difference `Z − Zh`, then scales the sum by the inverse of 2 and the difference by the inverse of `2·q`, all modulo `m`. The modulus and the root are parameters. The two inverse constants are derived from them during elaboration. Each conversion takes exactly two clock cycles from input strobe to output strobe, and a new pair may be accepted on every cycle. Recombination across several moduli and conversion back to signed binary belong to other blocks.

Top module: `qrns_inv_conv`

## Requirements
- R1: While `rst_n` is low, and after it is released until a result emerges, `out_valid` is 0 and `out_re` and `out_im` are 0.
- R2: `out_valid` is high exactly in the cycle two rising edges after a cycle with `in_valid` high, so one pair can be accepted every cycle.
- R3: `out_re` equals `INV2·(Z + Zh) mod MOD`, where `INV2` is the value with `2·INV2 mod MOD = 1`.
- R4: `out_im` equals `INV2·QINV·(Z − Zh) mod MOD`, where `QINV` satisfies `ROOT·QINV mod MOD = 1`; when `Z < Zh` the difference wraps by adding `MOD`.
- R5: With `MOD = 13` and `ROOT = 5`, the input pair `Z = 5`, `Zh = 3` gives `out_re = 4` and `out_im = 8`.
- R6: Whenever `out_valid` is high, both `out_re` and `out_im` lie in `[0, MOD−1]`.
- R7: In a cycle where `out_valid` is low, `out_re` and `out_im` keep the value they had in the previous cycle.
- R8: For each result, `(out_re + ROOT·out_im) mod MOD` equals the `Z` and `(out_re − ROOT·out_im) mod MOD` equals the `Zh` of the pair that produced it.
- R9: A pair whose sum equals `MOD` gives `out_re = 0`, and a pair with `Z = Zh` gives `out_im = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair strobe |
| in_z | input | RW | First residue `Z`, in `[0, MOD−1]` |
| in_zh | input | RW | Conjugate residue `Zh`, in `[0, MOD−1]` |
| out_valid | output | 1 | Result strobe |
| out_re | output | RW | Real residue modulo `MOD` |
| out_im | output | RW | Imaginary residue modulo `MOD` |

## Verification
The assertions take for granted that both residues are already reduced below `MOD` whenever `in_valid` is high, and that `ROOT` really is a square root of −1 modulo a prime `MOD`. Under those conditions, the range checks on the internal sum and difference and the round-trip property back to `Z` and `Zh` are meaningful. The stimulus draws every residue as a random value taken modulo `MOD`, so it never leaves the legal range. Directed pairs at 0, `MOD−1`, sums equal to `MOD` and equal operands cover the wrap boundaries.

// File: rtl/qrns_inv_pkg.sv
package qrns_inv_pkg;

  // Multiplicative inverse of a modulo m by search; used only at elaboration.
  function automatic int mod_inverse(input int m, input int a);
    int res;
    res = 0;
    for (int x = 1; x < m; x++) begin
      if (((a % m) * x) % m == 1) res = x;
    end
    return res;
  endfunction

  // Product of two constants reduced modulo m.
  function automatic int mod_mul(input int m, input int a, input int b);
    return (a * b) % m;
  endfunction

endpackage

// File: rtl/qrns_mod_addsub.sv
module qrns_mod_addsub #(
  parameter int MOD = 13,
  parameter int RW  = $clog2(MOD)
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] sum_mod,
  output logic [RW-1:0] dif_mod
);
  localparam int EW = RW + 2;
  localparam logic [EW-1:0] MOD_E = EW'(MOD);

  logic [EW-1:0] sum_raw;
  logic [EW-1:0] sum_less;
  logic [EW-1:0] dif_raw;
  logic [EW-1:0] dif_more;

  // Both candidates are formed side by side; the sign of the corrected
  // value picks the result.
  always_comb begin
    sum_raw  = EW'(a) + EW'(b);
    sum_less = sum_raw - MOD_E;
    dif_raw  = EW'(a) - EW'(b);
    dif_more = dif_raw + MOD_E;
    if (sum_less[EW-1]) sum_mod = RW'(sum_raw);
    else                sum_mod = RW'(sum_less);
    if (dif_raw[EW-1])  dif_mod = RW'(dif_more);
    else                dif_mod = RW'(dif_raw);
  end

endmodule

// File: rtl/qrns_const_scale.sv
module qrns_const_scale #(
  parameter int MOD  = 13,
  parameter int KVAL = 7,
  parameter int RW   = $clog2(MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] d,
  output logic [RW-1:0] q
);
  localparam int PW = 2 * RW;
  localparam logic [PW-1:0] K_P   = PW'(KVAL);
  localparam logic [PW-1:0] MOD_P = PW'(MOD);

  logic [PW-1:0] prod;
  logic [RW-1:0] q_nxt;

  always_comb begin
    prod  = PW'(d) * K_P;
    q_nxt = q;
    if (en) q_nxt = RW'(prod % MOD_P);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R7: register holds when not enabled
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  // R6: scaled value is always reduced
  assert_scaled_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q < RW'(MOD));

endmodule

// File: rtl/qrns_inv_conv.sv
module qrns_inv_conv #(
  parameter int MOD  = 13,
  parameter int ROOT = 5,
  parameter int RW   = $clog2(MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [RW-1:0] in_z,
  input  logic [RW-1:0] in_zh,
  output logic          out_valid,
  output logic [RW-1:0] out_re,
  output logic [RW-1:0] out_im
);
  import qrns_inv_pkg::*;

  localparam int INV2   = mod_inverse(MOD, 2);
  localparam int QINV   = mod_inverse(MOD, ROOT);
  localparam int K_IMAG = mod_mul(MOD, INV2, QINV);

  logic [RW-1:0] sum_c, dif_c;
  logic [RW-1:0] s1_sum, s1_dif, s1_sum_nxt, s1_dif_nxt;
  logic          s1_vld, s1_vld_nxt;
  logic          o_vld_nxt;

  qrns_mod_addsub #(.MOD(MOD), .RW(RW)) u_addsub (
    .a       (in_z),
    .b       (in_zh),
    .sum_mod (sum_c),
    .dif_mod (dif_c)
  );

  // Stage 1: modular sum and difference
  always_comb begin
    s1_vld_nxt = in_valid;
    s1_sum_nxt = s1_sum;
    s1_dif_nxt = s1_dif;
    if (in_valid) begin
      s1_sum_nxt = sum_c;
      s1_dif_nxt = dif_c;
    end
    o_vld_nxt = s1_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_sum    <= '0;
      s1_dif    <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_vld    <= s1_vld_nxt;
      s1_sum    <= s1_sum_nxt;
      s1_dif    <= s1_dif_nxt;
      out_valid <= o_vld_nxt;
    end
  end

  // Stage 2: constant scaling, registered
  qrns_const_scale #(.MOD(MOD), .KVAL(INV2), .RW(RW)) u_scale_re (
    .clk (clk), .rst_n (rst_n), .en (s1_vld), .d (s1_sum), .q (out_re)
  );
  qrns_const_scale #(.MOD(MOD), .KVAL(K_IMAG), .RW(RW)) u_scale_im (
    .clk (clk), .rst_n (rst_n), .en (s1_vld), .d (s1_dif), .q (out_im)
  );

  // Input contract
  assert_inputs_reduced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_z < RW'(MOD)) && (in_zh < RW'(MOD)));
  // R6: intermediate sum and difference reduced
  assert_stage1_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_sum < RW'(MOD)) && (s1_dif < RW'(MOD)));
  // R2: two-cycle strobe latency
  assert_latency_stage1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld == $past(in_valid));
  assert_latency_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_vld));
  // R8: result maps back to the input pair
  assert_round_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((int'(out_re) + ROOT * int'(out_im)) % MOD) == int'($past(in_z, 2)));
  assert_round_trip_conj_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((int'(out_re) + (MOD - ROOT) * int'(out_im)) % MOD) == int'($past(in_zh, 2)));

endmodule

// File: tb/qrns_inv_conv_tb.sv
module qrns_inv_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MOD  = 13;
  localparam int ROOT = 5;
  localparam int RW   = $clog2(MOD);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [RW-1:0] in_z, in_zh;
  logic out_valid;
  logic [RW-1:0] out_re, out_im;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrns_inv_conv #(.MOD(MOD), .ROOT(ROOT)) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_z (in_z), .in_zh (in_zh),
    .out_valid (out_valid), .out_re (out_re), .out_im (out_im)
  );

  function automatic int inv_of(input int a);
    for (int x = 1; x < MOD; x++) if ((a * x) % MOD == 1) return x;
    return 0;
  endfunction

  function automatic int exp_re(input int z, input int zh);
    return (inv_of(2) * ((z + zh) % MOD)) % MOD;
  endfunction

  function automatic int exp_im(input int z, input int zh);
    int d;
    d = (z - zh + MOD) % MOD;
    return (((inv_of(2) * inv_of(ROOT)) % MOD) * d) % MOD;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side two-deep history of driven inputs
  bit p1_v, p2_v;
  int p1_z, p1_zh, p2_z, p2_zh;
  int hold_re, hold_im;

  task automatic step(input bit v, input int z, input int zh);
    @(negedge clk);
    if (p2_v) begin
      check("R2 out_valid", int'(out_valid), 1);
      check("R3 out_re", int'(out_re), exp_re(p2_z, p2_zh));
      check("R4 out_im", int'(out_im), exp_im(p2_z, p2_zh));
      check("R6 range", int'(out_re < MOD && out_im < MOD), 1);
      check("R8 back to Z", (int'(out_re) + ROOT * int'(out_im)) % MOD, p2_z);
      check("R8 back to Zh", (int'(out_re) + (MOD - ROOT) * int'(out_im)) % MOD, p2_zh);
      if ((p2_z + p2_zh) == MOD) check("R9 sum equals MOD", int'(out_re), 0);
      if (p2_z == p2_zh)         check("R9 equal operands", int'(out_im), 0);
      hold_re = exp_re(p2_z, p2_zh);
      hold_im = exp_im(p2_z, p2_zh);
    end else begin
      check("R2 out_valid low", int'(out_valid), 0);
      check("R7 re held", int'(out_re), hold_re);
      check("R7 im held", int'(out_im), hold_im);
    end
    p2_v = p1_v; p2_z = p1_z; p2_zh = p1_zh;
    p1_v = v;    p1_z = z;    p1_zh = zh;
    in_valid = v;
    in_z  = RW'(z);
    in_zh = RW'(zh);
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; in_valid = 1'b0; in_z = '0; in_zh = '0;
    p1_v = 0; p2_v = 0; p1_z = 0; p1_zh = 0; p2_z = 0; p2_zh = 0;
    hold_re = 0; hold_im = 0;
    seed = $urandom(32'd4711);
    #(3*CLK_PERIOD + 2);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset re", int'(out_re), 0);
    check("R1 reset im", int'(out_im), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    // R5 worked example
    step(1, 5, 3);
    step(0, 0, 0);
    step(0, 0, 0);
    check("R5 example re", int'(out_re), 4);
    check("R5 example im", int'(out_im), 8);
    // Directed corners (R9, R4 wrap)
    step(1, 0, 0);
    step(1, MOD-1, MOD-1);
    step(1, 6, 7);
    step(1, 1, MOD-1);
    step(1, 0, MOD-1);
    step(1, MOD-1, 0);
    step(1, 2, 11);
    step(0, 9, 4);
    step(0, 3, 3);
    // Random stream
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, int'($urandom % MOD), int'($urandom % MOD));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20000 * CLK_PERIOD);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule